// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block derives periodic interrupt events from a 32768 Hz time base that arrives as a one-cycle enable on the system clock. A free-running 14-bit count advances on each time-base enable. A 4-bit rate code selects a power-of-two period in time-base cycles. An event fires whenever the count reaches a whole multiple of that period, so events stay locked to period boundaries of the shared count and do not depend on when the code was written.

Two enable bits decide what happens on an event. The interrupt enable raises an interrupt-request strobe. The square-wave enable emits a single-cycle pulse, not a toggling waveform. Every event also raises a flag-set strobe. The generator runs only when the code is nonzero and at least one enable is set. All three outputs are plain one-cycle strobes with no handshake. The surrounding status logic latches the flag and the request.

Top module: `prg_periodic_gen`

## Requirements
- R1: A rate code of 0 produces no flag, request or pulse strobe, whatever the enables are.
- R2: With a nonzero code but both enables clear, no strobe is produced.
- R3: Codes 1 and 2 behave as codes 8 and 9, giving periods of 128 and 256 time-base cycles.
- R4: Codes 3 to 15 give a period of 2^(code-1) time-base cycles, from 4 up to 16384.
- R5: The count is 14 bits wide, starts at 0 after reset, adds one on each enable and wraps modulo 16384. An event occurs on the enable that brings the count to a multiple of the period.
- R6: Each event raises the flag-set strobe for exactly one clock, in the clock that follows the enable cycle.
- R7: The interrupt-request strobe accompanies an event only when the interrupt enable is set.
- R8: The square-wave pulse accompanies an event only when the square-wave enable is set, and lasts one clock.
- R9: In a clock without a time-base enable, no strobe fires and the count does not advance.
- R10: A change of code or enables never resets the count. The new setting applies from the next enable.
- R11: During and right after reset, all three strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick32_en | input | 1 | One-cycle enable at the 32768 Hz rate |
| rate_sel | input | 4 | Rate code; 0 stops the generator |
| pie_en | input | 1 | Periodic interrupt enable |
| sqw_en | input | 1 | Square-wave pulse enable |
| flag_set_o | output | 1 | One-cycle strobe that sets the periodic flag |
| irq_req_o | output | 1 | One-cycle interrupt-request strobe |
| sqw_pulse_o | output | 1 | One-cycle square-wave pulse |

## Verification
The hardest cases to reach are the long periods and the realignment after a code change. An event with code 15 needs 16384 enables, and the count is never reset when the code moves on. The stimulus therefore keeps the time-base enable high for runs of two full periods per code, across all sixteen codes in one pass without reset. A bench-side count follows the count through the wrap. Later passes switch the code in the middle of a period and thin out the enables with gaps, so that event phase and alignment are checked on every clock.

// File: rtl/prg_pkg.sv
package prg_pkg;
  localparam int unsigned CNT_W     = 14;
  localparam int unsigned RATE_W    = 4;
  localparam int unsigned SHIFT_W   = 4;
  localparam int unsigned ALIAS_MAX = 2;
  localparam int unsigned ALIAS_ADD = 7;

  typedef logic [CNT_W-1:0]   cnt_t;
  typedef logic [RATE_W-1:0]  rate_t;
  typedef logic [SHIFT_W-1:0] shift_t;

  typedef struct packed {
    logic flag;
    logic irq;
    logic sqw;
  } evt_t;

  // Period exponent: codes up to ALIAS_MAX are folded upward, then minus one.
  function automatic shift_t rate_to_shift(input rate_t code);
    rate_t eff;
    eff = (code <= rate_t'(ALIAS_MAX)) ? rate_t'(code + rate_t'(ALIAS_ADD)) : code;
    return shift_t'(eff - rate_t'(1));
  endfunction
endpackage

// File: rtl/prg_free_counter.sv
module prg_free_counter
  import prg_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_nxt
);
  assign cnt_nxt = cnt_q + W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (adv) cnt_q <= cnt_nxt;
  end

  AST_HOLD_WITHOUT_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(cnt_q)) else $error("count moved without enable"); // R9
  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (cnt_q == W'($past(cnt_q) + 1))) else $error("count skipped"); // R5
endmodule

// File: rtl/prg_rate_decode.sv
module prg_rate_decode
  import prg_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              pie_en,
  input  logic              sqw_en,
  output logic              run,
  output logic [W-1:0]      mask
);
  shift_t shift;

  assign shift = rate_to_shift(rate_sel);
  assign run   = (rate_sel != '0) && (pie_en || sqw_en);

  // One mask bit per count bit: set below the period exponent.
  for (genvar i = 0; i < W; i++) begin : g_mask
    assign mask[i] = (shift > shift_t'(i));
  end
endmodule

// File: rtl/prg_event_gen.sv
module prg_event_gen
  import prg_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         run,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] cnt_nxt,
  input  logic         pie_en,
  input  logic         sqw_en,
  output evt_t         evt_q
);
  logic hit;

  assign hit = adv && run && ((cnt_nxt & mask) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= '0;
    end else begin
      evt_q.flag <= hit;
      evt_q.irq  <= hit && pie_en;
      evt_q.sqw  <= hit && sqw_en;
    end
  end

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q.irq |-> evt_q.flag) else $error("request without flag"); // R7
  AST_SQW_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q.sqw |-> evt_q.flag) else $error("pulse without flag"); // R8
  AST_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q.flag |=> !evt_q.flag) else $error("flag held two clocks"); // R6
  AST_NO_EN_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> !evt_q.flag) else $error("event without enable"); // R9
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (evt_q == '0)) else $error("event while stopped"); // R2
endmodule

// File: rtl/prg_periodic_gen.sv
module prg_periodic_gen
  import prg_pkg::*;
#(
  parameter int unsigned CW = CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick32_en,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              pie_en,
  input  logic              sqw_en,
  output logic              flag_set_o,
  output logic              irq_req_o,
  output logic              sqw_pulse_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nxt;
  logic [CW-1:0] mask;
  logic          run;
  evt_t          evt;

  prg_free_counter #(.W(CW)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (tick32_en),
    .cnt_q   (cnt_q),
    .cnt_nxt (cnt_nxt)
  );

  prg_rate_decode #(.W(CW)) u_dec (
    .rate_sel (rate_sel),
    .pie_en   (pie_en),
    .sqw_en   (sqw_en),
    .run      (run),
    .mask     (mask)
  );

  prg_event_gen #(.W(CW)) u_evt (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (tick32_en),
    .run     (run),
    .mask    (mask),
    .cnt_nxt (cnt_nxt),
    .pie_en  (pie_en),
    .sqw_en  (sqw_en),
    .evt_q   (evt)
  );

  assign flag_set_o  = evt.flag;
  assign irq_req_o   = evt.irq;
  assign sqw_pulse_o = evt.sqw;

  AST_CODE0_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel == '0) |=> !flag_set_o) else $error("event with code 0"); // R1
endmodule

// File: tb/prg_periodic_gen_test.sv
module prg_periodic_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick32_en = 1'b0;
  logic [3:0] rate_sel = 4'd0;
  logic       pie_en = 1'b0;
  logic       sqw_en = 1'b0;
  logic       flag_set_o, irq_req_o, sqw_pulse_o;

  int checks = 0;
  int fails  = 0;
  int cnt_m  = 0;
  int cyc    = 0;
  string ctx = "R11";

  always #5 clk = ~clk;

  prg_periodic_gen uut (
    .clk(clk), .rst_n(rst_n), .tick32_en(tick32_en), .rate_sel(rate_sel),
    .pie_en(pie_en), .sqw_en(sqw_en), .flag_set_o(flag_set_o),
    .irq_req_o(irq_req_o), .sqw_pulse_o(sqw_pulse_o)
  );

  function automatic int period_of(input int code);
    int e;
    e = (code <= 2) ? code + 7 : code;
    return 1 << (e - 1);
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d code %0d count %0d: actual %0b expected %0b",
               tag, cyc, rate_sel, cnt_m, act, exp);
    end
  endtask

  // Drive at negedge, model the enable edge, compare at the next negedge (R6).
  task automatic step(input logic en);
    logic run, ef;
    tick32_en = en;
    @(posedge clk);
    run = (rate_sel != 0) && (pie_en || sqw_en);
    if (en) cnt_m = (cnt_m + 1) % 16384;          // R5 wrap
    ef = en && run && ((cnt_m % period_of(int'(rate_sel))) == 0);
    @(negedge clk);
    chk(ctx, flag_set_o, ef);
    chk("R7", irq_req_o, ef && pie_en);
    chk("R8", sqw_pulse_o, ef && sqw_en);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual expired expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R11", flag_set_o, 1'b0);
    chk("R11", irq_req_o, 1'b0);
    chk("R11", sqw_pulse_o, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", flag_set_o, 1'b0);

    // Sweep every code with both enables, two periods each, no reset between.
    pie_en = 1'b1; sqw_en = 1'b1;
    for (int c = 0; c < 16; c++) begin
      rate_sel = 4'(c);
      ctx = (c == 0) ? "R1" : (c <= 2) ? "R3" : "R4";
      n = (c == 0) ? 40 : 2 * period_of(c) + 3;
      for (int i = 0; i < n; i++) step(1'b1);
    end

    // Every enable combination over small codes.
    for (int m = 0; m < 4; m++) begin
      pie_en = m[0]; sqw_en = m[1];
      for (int c = 3; c < 7; c++) begin
        rate_sel = 4'(c);
        ctx = (m == 0) ? "R2" : "R5";
        for (int i = 0; i < 2 * period_of(c) + 2; i++) step(1'b1);
      end
    end

    // Gaps in the time base: no advance and no event while idle.
    pie_en = 1'b1; sqw_en = 1'b0; rate_sel = 4'd4; ctx = "R9";
    for (int i = 0; i < 90; i++) step((i % 3) != 0);

    // Code switched in mid-period; alignment follows the running count.
    ctx = "R10";
    for (int k = 0; k < 12; k++) begin
      rate_sel = 4'(3 + (k % 4));
      pie_en = k[0]; sqw_en = ~k[0];
      for (int i = 0; i < 7 + k; i++) step(1'b1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule